// File: doc/BRIEF.md
# Inverter Delay Chain Sequencer

This block drives the control nodes of a behaviourally modelled chain of inverters that forms a pulse of selectable width, aligned to a clock edge. Every stage input node receives one of three commands each half clock period: pull it high, pull it low, or let it go so that the output of the stage ahead sets it. In the reset half of each period all nodes are pulled to alternating levels, so that the chain output sits low. In the launch half the nodes closest to the output are let go, and one node is flipped. The edge then crosses exactly the number of inverters that the delay code asks for.

The delay code and the edge-alignment choice are captured on each rising clock edge and held for the whole period that follows. An out-of-range code is clamped to the nearest legal delay and sets a sticky error flag. The registered patterns are merged with the clock through AND/OR gating, so the commands at the pins change in step with the clock edge that begins each half period.

Top module: `dcs_sequencer`

## Requirements
- R1: Stage k is controlled by `stage_ctrl[2k+1:2k]`. The code 2'b11 drives the node high, 2'b10 drives it low, and 2'b00 releases it. The code 2'b01 never appears.
- R2: Outside the launch phase, every stage is driven. Stages whose distance to the last stage (24 - k) is even are driven high and the others low, so the chain output, the inverse of the last node, is low.
- R3: In the launch phase with an effective delay N, stage 25 - N is driven opposite to its R2 level and every later stage is released. The edge therefore crosses exactly N inverters and the chain output goes high.
- R4: In the launch phase, every stage ahead of the launch stage keeps its R2 level.
- R5: With `align_fall` = 0 the launch phase is the high half of the clock; with `align_fall` = 1 it is the low half. `launch` is high exactly during the launch phase.
- R6: `delay_code` and `align_fall` are captured at each rising clock edge and govern the period that follows. A change inside a launch phase does not alter that phase's controls.
- R7: A captured code of 0 acts as delay 1. A captured code above 25 acts as delay 25.
- R8: `code_err` rises at the rising edge that captures an illegal code (0, or 26 to 31) and stays high until reset.
- R9: While `rst_n` is low at a rising edge, the block holds the R2 pattern, `launch` = 0 and `code_err` = 0. The first launch follows the first rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both halves are used |
| rst_n | input | 1 | Synchronous active-low reset |
| delay_code | input | 5 | Requested number of inverter delays |
| align_fall | input | 1 | 0: pulse at rising edge, 1: pulse at falling edge |
| stage_ctrl | output | 50 | Two-bit command per stage node |
| launch | output | 1 | High during the launch phase |
| code_err | output | 1 | Sticky flag for a clamped code |

## Verification
The hardest situation to reach is a code change that lands inside the launch half of the very period whose code has already been captured. The phases are only half a period long, and which clock level they occupy depends on the alignment. The stimulus therefore changes the code at fixed half-period offsets after the capturing rising edge, in both alignments. It samples the commands later in the same launch half, and then in the next period, to show that the new code is taken only at the following rising edge. A behavioural chain model evaluates every sampled pattern. It finds the launch node and the chain output level, so the inverter count is checked as a property of the resolved chain rather than only as a bit pattern.

// File: rtl/dcs_pkg.sv
// Package dcs_pkg: the stage command encoding and the preset-level rule
// that are shared by the sequencer, its checker and its sub-blocks.
package dcs_pkg;

    typedef logic [1:0] stage_cmd_t;

    localparam stage_cmd_t CMD_FLOAT = 2'b00;
    localparam stage_cmd_t CMD_LOW   = 2'b10;
    localparam stage_cmd_t CMD_HIGH  = 2'b11;

    // Reset-phase command of node idx. A node an even number of stages
    // ahead of the last node is high, which leaves the chain output low.
    function automatic stage_cmd_t preset_cmd(input int idx, input int last);
        return (((last - idx) % 2) == 0) ? CMD_HIGH : CMD_LOW;
    endfunction

    // The command that flips a node away from its preset level.
    function automatic stage_cmd_t flip_cmd(input stage_cmd_t p);
        return {1'b1, ~p[0]};
    endfunction

endpackage

// File: rtl/dcs_code_sampler.sv
// dcs_code_sampler: clamps the incoming delay code into 1..NUM_STAGES and
// registers the alignment choice, a run flag and the sticky error flag.
// Assumes that the code is only meaningful at rising clock edges.
module dcs_code_sampler #(
    parameter int NUM_STAGES = 25,
    localparam int CODE_W = $clog2(NUM_STAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              fall_in,
    output logic [CODE_W-1:0] code_legal,
    output logic              fall_q,
    output logic              run_q,
    output logic              err_q
);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_STAGES);

    logic too_low;
    logic too_high;

    // Range test and clamp of the raw code.
    always_comb begin
        too_low    = (code_in == '0);
        too_high   = (code_in > MAX_CODE);
        code_legal = too_low  ? CODE_W'(1) :
                     too_high ? MAX_CODE   : code_in;
    end

    // Capture of the alignment, the run flag and the sticky error once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
            run_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            fall_q <= fall_in;
            run_q  <= 1'b1;
            err_q  <= err_q | too_low | too_high;
        end
    end

endmodule

// File: rtl/dcs_pattern_gen.sv
// dcs_pattern_gen: registers the launch-phase command of every stage for
// the captured delay. Stages ahead of the launch node keep their preset,
// the launch node is flipped, and later stages are released.
// Assumes that code_legal already lies within 1..NUM_STAGES.
module dcs_pattern_gen #(
    parameter int NUM_STAGES = 25,
    localparam int CODE_W = $clog2(NUM_STAGES + 1),
    localparam int CTRL_W = 2 * NUM_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_legal,
    output logic [CTRL_W-1:0] launch_pat
);
    logic [CODE_W-1:0] launch_idx;

    // The index of the node that starts the edge.
    always_comb launch_idx = CODE_W'(NUM_STAGES) - code_legal;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        localparam dcs_pkg::stage_cmd_t PRE = dcs_pkg::preset_cmd(k, NUM_STAGES - 1);

        // Per-stage launch command, reloaded at every rising edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                launch_pat[2*k +: 2] <= PRE;
            end else if (CODE_W'(k) < launch_idx) begin
                launch_pat[2*k +: 2] <= PRE;
            end else if (CODE_W'(k) == launch_idx) begin
                launch_pat[2*k +: 2] <= dcs_pkg::flip_cmd(PRE);
            end else begin
                launch_pat[2*k +: 2] <= dcs_pkg::CMD_FLOAT;
            end
        end
    end

endmodule

// File: rtl/dcs_phase_gate.sv
// dcs_phase_gate: merges the registered launch pattern with the fixed
// preset pattern, using AND/OR gating with the true or inverted clock.
// Assumes that the launch pattern and fall_q only change at rising edges.
module dcs_phase_gate #(
    parameter int NUM_STAGES = 25,
    localparam int CTRL_W = 2 * NUM_STAGES
) (
    input  logic              clk,
    input  logic              fall_q,
    input  logic              run_q,
    input  logic [CTRL_W-1:0] launch_pat,
    output logic [CTRL_W-1:0] stage_ctrl,
    output logic              fire
);
    // The launch phase is the selected clock half, once the block is running.
    always_comb fire = (clk ^ fall_q) & run_q;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_gate
        localparam dcs_pkg::stage_cmd_t PRE = dcs_pkg::preset_cmd(k, NUM_STAGES - 1);

        // Per-stage AND/OR selection between the launch and preset commands.
        always_comb stage_ctrl[2*k +: 2] = (launch_pat[2*k +: 2] & {2{fire}})
                                         | (PRE & {2{~fire}});
    end

endmodule

// File: rtl/dcs_sequencer.sv
// dcs_sequencer: top level of the inverter delay chain sequencer. It
// samples the delay code each period, builds the per-stage launch pattern
// and gates it with the clock half that is selected for the pulse.
// Assumes a free-running clk and a synchronous active-low reset.
module dcs_sequencer #(
    parameter int NUM_STAGES = 25,
    localparam int CODE_W = $clog2(NUM_STAGES + 1),
    localparam int CTRL_W = 2 * NUM_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] delay_code,
    input  logic              align_fall,
    output logic [CTRL_W-1:0] stage_ctrl,
    output logic              launch,
    output logic              code_err
);
    logic [CODE_W-1:0] code_legal;
    logic              fall_q;
    logic              run_q;
    logic [CTRL_W-1:0] launch_pat;

    dcs_code_sampler #(.NUM_STAGES(NUM_STAGES)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_in    (delay_code),
        .fall_in    (align_fall),
        .code_legal (code_legal),
        .fall_q     (fall_q),
        .run_q      (run_q),
        .err_q      (code_err)
    );

    dcs_pattern_gen #(.NUM_STAGES(NUM_STAGES)) u_pattern (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_legal (code_legal),
        .launch_pat (launch_pat)
    );

    dcs_phase_gate #(.NUM_STAGES(NUM_STAGES)) u_gate (
        .clk        (clk),
        .fall_q     (fall_q),
        .run_q      (run_q),
        .launch_pat (launch_pat),
        .stage_ctrl (stage_ctrl),
        .fire       (launch)
    );

endmodule

// File: rtl/dcs_seq_chk.sv
// dcs_seq_chk: property checker for dcs_sequencer, attached by bind.
// It checks the command encoding, the idle preset, the single flipped node
// in each launch phase, and the sticky error flag.
module dcs_seq_chk #(
    parameter int NUM_STAGES = 25,
    localparam int CTRL_W = 2 * NUM_STAGES
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] stage_ctrl,
    input logic              launch,
    input logic              code_err
);
    logic [NUM_STAGES-1:0] bad_enc;
    logic [NUM_STAGES-1:0] off_preset;
    logic [NUM_STAGES-1:0] flipped;

    // Per-stage classification of the command that is present on the pins.
    always_comb begin
        for (int k = 0; k < NUM_STAGES; k++) begin
            bad_enc[k]    = (stage_ctrl[2*k +: 2] == 2'b01);
            off_preset[k] = (stage_ctrl[2*k +: 2] != dcs_pkg::preset_cmd(k, NUM_STAGES - 1));
            flipped[k]    = stage_ctrl[2*k+1] && off_preset[k];
        end
    end

    // R1
    no_bad_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_enc == '0);

    // R2
    idle_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |-> (off_preset == '0));

    // R3
    one_flip_rise_chk: assert property (@(negedge clk) disable iff (!rst_n)
        launch |-> ($countones(flipped) == 1));

    // R3
    one_flip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> ($countones(flipped) == 1));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> code_err);

endmodule

bind dcs_sequencer dcs_seq_chk #(.NUM_STAGES(NUM_STAGES)) u_dcs_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_ctrl (stage_ctrl),
    .launch     (launch),
    .code_err   (code_err)
);

// File: tb/dcs_sequencer_bench.sv
`timescale 1ns/1ps
// Bench for dcs_sequencer: sweeps every code in both alignments, resolves
// each sampled command pattern through a behavioural inverter chain, and
// checks capture timing, clamping, the sticky flag and reset.
module dcs_sequencer_bench;
    localparam int NS = 25;
    localparam int CW = 2 * NS;

    logic          clk;
    logic          rst_n;
    logic [4:0]    delay_code;
    logic          align_fall;
    logic [CW-1:0] stage_ctrl;
    logic          launch;
    logic          code_err;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  exp_err  = 1'b0;
    bit  finished = 1'b0;

    dcs_sequencer #(.NUM_STAGES(NS)) u_dcs_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .delay_code (delay_code),
        .align_fall (align_fall),
        .stage_ctrl (stage_ctrl),
        .launch     (launch),
        .code_err   (code_err)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [1:0] pre_lvl(int k);
        return (((NS - 1 - k) % 2) == 0) ? 2'b11 : 2'b10;
    endfunction

    function automatic logic [CW-1:0] exp_preset();
        logic [CW-1:0] v;
        for (int k = 0; k < NS; k++) v[2*k +: 2] = pre_lvl(k);
        return v;
    endfunction

    function automatic int clamp(int c);
        return (c < 1) ? 1 : ((c > NS) ? NS : c);
    endfunction

    function automatic logic [CW-1:0] exp_launch(int n);
        logic [CW-1:0] v;
        int lp;
        lp = NS - n;
        for (int k = 0; k < NS; k++) begin
            if (k < lp)       v[2*k +: 2] = pre_lvl(k);
            else if (k == lp) v[2*k +: 2] = {1'b1, ~pre_lvl(k)[0]};
            else              v[2*k +: 2] = 2'b00;
        end
        return v;
    endfunction

    // Behavioural chain: a released node follows the inverse of the node before it.
    function automatic logic chain_out(logic [CW-1:0] c);
        logic v;
        v = 1'b0;
        for (int k = 0; k < NS; k++) v = c[2*k+1] ? c[2*k] : ~v;
        return ~v;
    endfunction

    // The number of inverters between the last driven node and the output.
    function automatic int chain_delay(logic [CW-1:0] c);
        int hi;
        hi = -1;
        for (int k = 0; k < NS; k++) if (c[2*k+1]) hi = k;
        return NS - hi;
    endfunction

    function automatic bit has_bad(logic [CW-1:0] c);
        for (int k = 0; k < NS; k++) if (c[2*k +: 2] == 2'b01) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Checks for a sample that falls inside a launch phase of delay n.
    task automatic launch_checks(int n, string req);
        chk(stage_ctrl == exp_launch(n), req, "launch pattern", 64'(stage_ctrl), 64'(exp_launch(n)));
        chk(chain_delay(stage_ctrl) == n, "R3", "inverter count", 64'(chain_delay(stage_ctrl)), 64'(n));
        chk(chain_out(stage_ctrl) == 1'b1, "R3", "chain output high", 64'(chain_out(stage_ctrl)), 64'd1);
        chk((stage_ctrl[2*(NS-n)-1 >= 0 ? 0 : 0 +: 2] == exp_launch(n)[1:0]) || (n == NS),
            "R4", "first stage keeps preset", 64'(stage_ctrl[1:0]), 64'(pre_lvl(0)));
        chk(!has_bad(stage_ctrl), "R1", "no 01 code", 64'(stage_ctrl), 64'd0);
        chk(launch == 1'b1, "R5", "launch strobe high", 64'(launch), 64'd1);
    endtask

    // Checks for a sample that falls inside a reset phase.
    task automatic idle_checks();
        chk(stage_ctrl == exp_preset(), "R2", "preset pattern", 64'(stage_ctrl), 64'(exp_preset()));
        chk(chain_out(stage_ctrl) == 1'b0, "R2", "chain output low", 64'(chain_out(stage_ctrl)), 64'd0);
        chk(launch == 1'b0, "R5", "launch strobe low", 64'(launch), 64'd0);
    endtask

    // One period with the given code and alignment; samples both halves.
    task automatic run_pulse(int code, bit fall);
        string req;
        req = (code < 1 || code > NS) ? "R7" : "R3";
        @(negedge clk);
        #1;
        delay_code = 5'(code);
        align_fall = fall;
        @(posedge clk);
        if (code < 1 || code > NS) exp_err = 1'b1;
        #2;
        if (fall) idle_checks(); else launch_checks(clamp(code), req);
        chk(code_err == exp_err, "R8", "sticky flag", 64'(code_err), 64'(exp_err));
        #4;
        if (fall) launch_checks(clamp(code), req); else idle_checks();
    endtask

    task automatic reset_checks();
        chk(stage_ctrl == exp_preset(), "R9", "preset under reset", 64'(stage_ctrl), 64'(exp_preset()));
        chk(launch == 1'b0, "R9", "no launch under reset", 64'(launch), 64'd0);
        chk(code_err == 1'b0, "R9", "flag cleared", 64'(code_err), 64'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        delay_code = 5'd1;
        align_fall = 1'b0;
        @(posedge clk);
        #2 reset_checks();
        #4 reset_checks();
        exp_err = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        delay_code = 5'd1;
        align_fall = 1'b0;
        repeat (3) @(posedge clk);
        #2 reset_checks();
        #4 reset_checks();
        @(negedge clk);
        rst_n = 1'b1;

        // Legal sweep, both alignments: the flag must stay low.
        for (int c = 1; c <= NS; c++) run_pulse(c, 1'b0);
        for (int c = 1; c <= NS; c++) run_pulse(c, 1'b1);

        // R7, R8: illegal codes clamp and set the flag, which then stays set.
        run_pulse(0, 1'b0);
        for (int c = NS + 1; c < 32; c++) run_pulse(c, 1'b0);
        run_pulse(9, 1'b0);
        do_reset();
        for (int c = NS + 1; c < 32; c++) run_pulse(c, 1'b1);
        run_pulse(0, 1'b1);
        run_pulse(4, 1'b1);
        do_reset();

        // R6: a change inside the rising-aligned launch half.
        @(negedge clk);
        #1 delay_code = 5'd5; align_fall = 1'b0;
        @(posedge clk);
        #1 delay_code = 5'd20;
        #2 chk(stage_ctrl == exp_launch(5), "R6", "rise hold", 64'(stage_ctrl), 64'(exp_launch(5)));
        @(posedge clk);
        #2 chk(stage_ctrl == exp_launch(20), "R6", "rise next period", 64'(stage_ctrl), 64'(exp_launch(20)));

        // R6: a change inside the falling-aligned launch half.
        @(negedge clk);
        #1 delay_code = 5'd7; align_fall = 1'b1;
        @(posedge clk);
        #5 delay_code = 5'd12;
        #2 chk(stage_ctrl == exp_launch(7), "R6", "fall hold", 64'(stage_ctrl), 64'(exp_launch(7)));
        @(posedge clk);
        #6 chk(stage_ctrl == exp_launch(12), "R6", "fall next period", 64'(stage_ctrl), 64'(exp_launch(12)));
        chk(code_err == 1'b0, "R8", "flag after legal codes", 64'(code_err), 64'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule